// File: doc/BRIEF.md
# FIFO Interrupt Controller

This block merges six FIFO condition flags into one interrupt request line. Each condition has its own enable bit, and a master enable sits above all six. When a condition is enabled and its flag is high, the block records it in a sticky pending bit. The pending bit stays set until software reads the pending register. That read clears every pending bit at once.

The pending vector is offered to the bus side as a plain output. The read strobe comes from the bus decoder when the pending register is read. The interrupt line is a registered OR of the pending bits, qualified by the master enable.

Each condition is tracked by a two-state machine:
- `SRC_CLEAR` moves to `SRC_LATCHED` on a qualified hit when there is no read strobe in the same cycle.
- `SRC_LATCHED` returns to `SRC_CLEAR` on the read strobe.

The output line has two states:
- `LINE_LOW` moves to `LINE_HIGH` when the master enable is set and any pending bit is set.
- `LINE_HIGH` falls back to `LINE_LOW` when either of those is absent.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `pend_status` is 0 and `irq` is 0.
- R2: A pending bit is set at the clock edge where the master enable, that condition's enable bit and that condition's flag are all 1. The bit is visible just after that edge.
- R3: While `master_en` is 0, no pending bit becomes set, whatever the flags and per-condition enables are.
- R4: A condition whose bit in `cond_en` is 0 never sets its pending bit.
- R5: A set pending bit stays set after its flag falls, until the pending register is read.
- R6: A clock edge with `pend_rd` high clears all pending bits to 0, even if a new hit arrives in that same cycle.
- R7: If a condition is still qualified during the clearing read, its pending bit reads 0 for one cycle and is set again at the following edge.
- R8: `irq` is registered. After each edge it equals the AND of `master_en` and the OR of `pend_status`, both sampled at that edge. It therefore lags the pending bits by one cycle, and clearing `master_en` drops it without touching the pending bits.
- R9: The bit order is the same in `cond_flags`, `cond_en` and `pend_status`, from bit 5 down to bit 0:
  - bit 5: programmable-empty
  - bit 4: programmable-full
  - bit 3: almost-empty
  - bit 2: almost-full
  - bit 1: empty
  - bit 0: full

  A flag on bit i only ever sets pending bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_flags | input | 6 | FIFO condition flags, in the R9 order |
| cond_en | input | 6 | Per-condition enables, in the same order |
| master_en | input | 1 | Master enable over all conditions |
| pend_rd | input | 1 | Strobe for a read of the pending register; clears it |
| irq | output | 1 | Registered interrupt request |
| pend_status | output | 6 | Sticky pending bits, in the same order |

## Verification
The hardest case to reach is a read strobe arriving while a condition is still qualified. Here the clear and the re-set compete on consecutive edges, and the pending bit must show exactly one cycle of zero. A directed sequence holds a flag high across the read so that this one-cycle gap is forced. A second case is the cycle where a read and a fresh hit on another bit coincide, where the clear must win. Random stimulus then mixes reads at roughly one cycle in eight with sparse flags and enables, so this case and related ones recur many times. A cycle model in the bench is compared with both outputs at every step.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    // Number of FIFO conditions handled by the controller
    localparam int NUM_COND = 6;

    // Bit positions shared by the flag, enable and pending vectors
    localparam int IDX_FULL       = 0;
    localparam int IDX_EMPTY      = 1;
    localparam int IDX_ALMOST_FUL = 2;
    localparam int IDX_ALMOST_EMP = 3;
    localparam int IDX_PROG_FULL  = 4;
    localparam int IDX_PROG_EMPTY = 5;

    // Per-condition sticky tracker
    typedef enum logic {
        SRC_CLEAR   = 1'b0,
        SRC_LATCHED = 1'b1
    } src_state_t;

    // Interrupt output line
    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_t;

endpackage

// File: rtl/fifo_irq_qualify.sv
module fifo_irq_qualify #(
    parameter int NUM_COND = fifo_irq_pkg::NUM_COND
) (
    input  logic [NUM_COND-1:0] flags,
    input  logic [NUM_COND-1:0] enables,
    input  logic                master_en,
    output logic [NUM_COND-1:0] hits
);

    // A condition counts only when all three gates agree
    always_comb begin
        hits = flags & enables & {NUM_COND{master_en}};
    end

endmodule

// File: rtl/fifo_irq_src_latch.sv
module fifo_irq_src_latch
    import fifo_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pending
);

    src_state_t state_q;
    src_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: the clearing read wins over a hit in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_CLEAR: begin
                if (hit && !clr) begin
                    state_d = SRC_LATCHED;
                end
            end
            SRC_LATCHED: begin
                if (clr) begin
                    state_d = SRC_CLEAR;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pending = (state_q == SRC_LATCHED);
    end

endmodule

// File: rtl/fifo_irq_line.sv
module fifo_irq_line
    import fifo_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    input  logic master_en,
    output logic irq
);

    line_state_t state_q;
    line_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW: begin
                if (master_en && any_pending) begin
                    state_d = LINE_HIGH;
                end
            end
            LINE_HIGH: begin
                if (!master_en || !any_pending) begin
                    state_d = LINE_LOW;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        irq = (state_q == LINE_HIGH);
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl #(
    parameter int NUM_COND = fifo_irq_pkg::NUM_COND
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_flags,
    input  logic [NUM_COND-1:0] cond_en,
    input  logic                master_en,
    input  logic                pend_rd,
    output logic                irq,
    output logic [NUM_COND-1:0] pend_status
);

    logic [NUM_COND-1:0] hits;
    logic                any_pending;

    fifo_irq_qualify #(
        .NUM_COND (NUM_COND)
    ) u_qualify (
        .flags     (cond_flags),
        .enables   (cond_en),
        .master_en (master_en),
        .hits      (hits)
    );

    // One sticky tracker per condition
    for (genvar g = 0; g < NUM_COND; g++) begin : g_src
        fifo_irq_src_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hits[g]),
            .clr     (pend_rd),
            .pending (pend_status[g])
        );
    end

    always_comb begin
        any_pending = |pend_status;
    end

    fifo_irq_line u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_pending (any_pending),
        .master_en   (master_en),
        .irq         (irq)
    );

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
    parameter int NUM_COND = fifo_irq_pkg::NUM_COND
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COND-1:0] cond_flags,
    input logic [NUM_COND-1:0] cond_en,
    input logic                master_en,
    input logic                pend_rd,
    input logic                irq,
    input logic [NUM_COND-1:0] pend_status
);

    // R6
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd |=> (pend_status == '0));

    // R3
    no_set_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> ((pend_status & ~$past(pend_status)) == '0));

    // R4
    no_set_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_status & ~$past(pend_status) & ~$past(cond_en)) == '0));

    // R2
    set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_rd && master_en) |=> ((pend_status & $past(cond_flags & cond_en)) == $past(cond_flags & cond_en)));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_rd |=> ((pend_status & $past(pend_status)) == $past(pend_status)));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ($past(master_en) && ($past(pend_status) != '0))));

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.NUM_COND(NUM_COND)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_flags  (cond_flags),
    .cond_en     (cond_en),
    .master_en   (master_en),
    .pend_rd     (pend_rd),
    .irq         (irq),
    .pend_status (pend_status)
);

// File: tb/fifo_irq_ctrl_test.sv
module fifo_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int RAND_STEPS = 3000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] cond_flags;
    logic [N-1:0] cond_en;
    logic         master_en;
    logic         pend_rd;
    logic         irq;
    logic [N-1:0] pend_status;

    int           n_checks = 0;
    int           n_fails  = 0;
    logic [N-1:0] m_stat;
    logic         m_irq;
    bit           done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_irq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_flags  (cond_flags),
        .cond_en     (cond_en),
        .master_en   (master_en),
        .pend_rd     (pend_rd),
        .irq         (irq),
        .pend_status (pend_status)
    );

    // Next pending vector predicted from the requirements
    function automatic logic [N-1:0] next_stat(input logic [N-1:0] cur, input logic [N-1:0] f,
                                               input logic [N-1:0] e, input logic g, input logic r);
        if (r) return '0;
        return cur | (g ? (f & e) : '0);
    endfunction

    // Next interrupt line predicted from the requirements
    function automatic logic next_irq(input logic [N-1:0] cur, input logic g);
        return g && (cur != '0);
    endfunction

    task automatic check_out(input string tag);
        n_checks++;
        if (pend_status !== m_stat) begin
            n_fails++;
            $display("FAIL %s pend_status actual=%b expected=%b", tag, pend_status, m_stat);
        end
        n_checks++;
        if (irq !== m_irq) begin
            n_fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
        end
    endtask

    task automatic step(input logic [N-1:0] f, input logic [N-1:0] e, input logic g,
                        input logic r, input string tag);
        logic [N-1:0] ns;
        logic         ni;
        cond_flags = f;
        cond_en    = e;
        master_en  = g;
        pend_rd    = r;
        ns = next_stat(m_stat, f, e, g, r);
        ni = next_irq(m_stat, g);
        @(posedge clk);
        #1;
        m_stat = ns;
        m_irq  = ni;
        check_out(tag);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n      = 1'b0;
        cond_flags = '0;
        cond_en    = '0;
        master_en  = 1'b0;
        pend_rd    = 1'b0;
        m_stat     = '0;
        m_irq      = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 in reset");
        rst_n = 1'b1;
        step('0, '1, 1'b1, 1'b0, "R1 after reset");

        // R2 R9: programmable-empty flag (bit 5) sets only pending bit 5
        step(6'b100000, 6'b111111, 1'b1, 1'b0, "R2 R9 bit5 set");
        // R8: line rises one cycle later; R5 flag dropped, bit held
        step(6'b000000, 6'b111111, 1'b1, 1'b0, "R5 R8 hold and irq");
        step(6'b000000, 6'b111111, 1'b1, 1'b0, "R5 hold");
        // R6: read clears, with a fresh hit on the full flag (bit 0) in the same cycle
        step(6'b000001, 6'b111111, 1'b1, 1'b1, "R6 read clears");
        step(6'b000000, 6'b111111, 1'b1, 1'b0, "R6 R8 irq falls");
        // R3: master enable off blocks every condition
        step(6'b111111, 6'b111111, 1'b0, 1'b0, "R3 masked");
        step(6'b111111, 6'b111111, 1'b0, 1'b0, "R3 masked again");
        // R4: only the enabled condition (full, bit 0) latches
        step(6'b111111, 6'b000001, 1'b1, 1'b0, "R4 single enable");
        // R7: read while full is still qualified
        step(6'b111111, 6'b000001, 1'b1, 1'b1, "R7 clear cycle");
        step(6'b111111, 6'b000001, 1'b1, 1'b0, "R7 re-set");
        // R8: master enable off drops irq, pending kept
        step(6'b000000, 6'b000001, 1'b0, 1'b0, "R8 gate off");
        step(6'b000000, 6'b000001, 1'b0, 1'b0, "R8 gate off hold");
        step(6'b000000, 6'b000001, 1'b1, 1'b0, "R8 gate back on");
        step(6'b000000, 6'b000001, 1'b1, 1'b1, "R6 final clear");
        // R9: each flag position alone maps to the same pending bit
        for (int i = 0; i < N; i++) begin
            step(N'(1) << i, '1, 1'b1, 1'b0, "R9 walk set");
            step('0, '1, 1'b1, 1'b1, "R9 walk clear");
        end

        // Random mix: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < RAND_STEPS; k++) begin
            logic [N-1:0] f;
            logic [N-1:0] e;
            f = N'($urandom) & N'($urandom);
            e = N'($urandom);
            step(f, e, ($urandom % 5) != 0, ($urandom % 8) == 0, "R2-mix random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule